// File: doc/BRIEF.md
# Maskable External Interrupt Unit

This unit collects up to 32 external interrupt lines for a processor core and presents them to software as two control registers: an enable register (one bit per line, 1 = enabled) and a pending register (one bit per line, 1 = pending). Each line's behaviour is fixed when the unit is built. A line can be edge-latched, where a pulse of one cycle or longer is held until software clears it. A line can be level-following, where the pending bit tracks the wire. A line can also be switched off for good.

The core sees one combined flag that is set when an enabled line is pending. It also sees an interrupt request, which is that flag gated by a global enable bit that the core owns. When software clears a latched pending bit, the unit sends a one-cycle end-of-interrupt strobe on that line's own output, whatever the enable settings are. A build parameter can remove the whole feature, which leaves every register and output at zero.

Register access follows the usual read-modify-write forms of a processor's control-register instructions. A plain write replaces the value, a set operation ORs the data in, and a clear operation removes the bits that are 1 in the data. The read data is combinational from the stored state.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, both registers read zero, the combined pending flag and the request are low, and every end-of-interrupt strobe is low.
- R2: With `csr_en_i` high, the operation code on `csr_op_i` is applied at the clock edge: 2'b01 writes the data, 2'b10 sets the bits that are 1 in the data, 2'b11 clears the bits that are 1 in the data, and 2'b00 only reads. Address 12'h7C0 selects the enable register and 12'h7C1 selects the pending register. Any other address reads zero and changes nothing.
- R3: A line whose bit is 1 in `OFF_LINES` never shows a pending bit and never shows an enable bit, whatever its input is and whatever is written.
- R4: On a line whose bit is 1 in `EDGE_LINES`, a high input sets the pending bit at the next edge. The bit then stays set after the input falls, until a register write clears it.
- R5: On any other line (level-following), the pending bit equals the input as sampled at the previous edge. Writes to that bit have no effect.
- R6: `ext_pend_o` is high exactly when at least one line has both its pending bit and its enable bit set. It falls when all such pending bits are cleared or masked.
- R7: `irq_req_o` equals `ext_pend_o` AND `glb_en_i`. The global enable has no effect on `ext_pend_o`.
- R8: When a register write changes pending bit n from 1 to 0, `eoi_o[n]` is high for exactly the one cycle after that edge. This holds regardless of the enable bit and the global enable.
- R9: If a latched line's input is high at the edge where software clears its pending bit, the bit stays set and no end-of-interrupt strobe is produced.
- R10: With `FEATURE_EN` = 0, the read data, `ext_pend_o`, `irq_req_o` and `eoi_o` stay zero for every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_LINES | External interrupt lines |
| csr_en_i | input | 1 | Register access strobe |
| csr_addr_i | input | 12 | Register address |
| csr_op_i | input | 2 | Operation: 00 read, 01 write, 10 set, 11 clear |
| csr_wdata_i | input | 32 | Operand for write, set or clear |
| glb_en_i | input | 1 | Global external interrupt enable from the core |
| csr_rdata_o | output | 32 | Read data of the addressed register |
| ext_pend_o | output | 1 | Combined external-pending flag |
| irq_req_o | output | 1 | Interrupt request to the core |
| eoi_o | output | NUM_LINES | One-cycle end-of-interrupt strobes |

## Verification
The pending logic is driven with single-cycle pulses on latched lines, held levels on level-following lines, and activity on switched-off lines. This separates holding, following and ignoring an input. The enable register is taken through write, set, clear, read-only and wrong-address accesses, which shows that each operation code and the decode act on their own. End-of-interrupt strobes are provoked with the line masked and the global enable low. A clear is also made to coincide with a fresh pulse, which tells a real 1-to-0 change apart from a write that loses to a new event. A second copy built without the feature receives the same stimulus and must stay silent.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam int unsigned XLEN   = 32;
    localparam int unsigned ADDR_W = 12;

    localparam logic [ADDR_W-1:0] ADDR_ENABLE  = 12'h7C0;
    localparam logic [ADDR_W-1:0] ADDR_PENDING = 12'h7C1;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_SET   = 2'b10,
        OP_CLEAR = 2'b11
    } csr_op_e;

endpackage

// File: rtl/ext_irq_csr_port.sv
module ext_irq_csr_port
    import ext_irq_pkg::*;
#(
    parameter int unsigned NL = 32
) (
    input  logic              en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        op_i,
    input  logic [XLEN-1:0]   wdata_i,
    input  logic [NL-1:0]     mask_q_i,
    input  logic [NL-1:0]     pend_q_i,
    output logic              mask_wr_o,
    output logic              pend_wr_o,
    output logic [NL-1:0]     mask_nv_o,
    output logic [NL-1:0]     pend_nv_o,
    output logic [XLEN-1:0]   rdata_o
);

    logic          hit_mask;
    logic          hit_pend;
    logic          do_write;
    logic [NL-1:0] operand;
    csr_op_e       op;

    assign op       = csr_op_e'(op_i);
    assign hit_mask = en_i && (addr_i == ADDR_ENABLE);
    assign hit_pend = en_i && (addr_i == ADDR_PENDING);
    assign do_write = (op != OP_READ);
    assign operand  = wdata_i[NL-1:0];

    function automatic logic [NL-1:0] modify(csr_op_e o, logic [NL-1:0] old, logic [NL-1:0] arg);
        logic [NL-1:0] res;
        case (o)
            OP_WRITE: res = arg;
            OP_SET:   res = old | arg;
            OP_CLEAR: res = old & ~arg;
            default:  res = old;
        endcase
        return res;
    endfunction

    always_comb begin
        mask_wr_o = hit_mask && do_write;
        pend_wr_o = hit_pend && do_write;
        mask_nv_o = modify(op, mask_q_i, operand);
        pend_nv_o = modify(op, pend_q_i, operand);
        rdata_o   = '0;
        if (hit_mask) begin
            rdata_o = XLEN'(mask_q_i);
        end else if (hit_pend) begin
            rdata_o = XLEN'(pend_q_i);
        end
    end

endmodule

// File: rtl/ext_irq_line.sv
module ext_irq_line #(
    parameter bit LATCHED = 1'b0,
    parameter bit OFF     = 1'b0
) (
    input  logic irq_i,
    input  logic pend_q_i,
    input  logic sw_wr_i,
    input  logic sw_val_i,
    output logic pend_d_o,
    output logic eoi_d_o
);

    logic held;
    logic held_next;

    always_comb begin
        held      = sw_wr_i ? sw_val_i : pend_q_i;
        held_next = held | irq_i;
        if (OFF) begin
            pend_d_o = 1'b0;
        end else if (LATCHED) begin
            pend_d_o = held_next;
        end else begin
            pend_d_o = irq_i;
        end
        eoi_d_o = LATCHED && !OFF && pend_q_i && !pend_d_o;
    end

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import ext_irq_pkg::*;
#(
    parameter int unsigned NUM_LINES  = 32,
    parameter logic [31:0] OFF_LINES  = 32'h0000_0000,
    parameter logic [31:0] EDGE_LINES = 32'hFFFF_FFFF,
    parameter bit          FEATURE_EN = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_i,
    input  logic                 csr_en_i,
    input  logic [11:0]          csr_addr_i,
    input  logic [1:0]           csr_op_i,
    input  logic [31:0]          csr_wdata_i,
    input  logic                 glb_en_i,
    output logic [31:0]          csr_rdata_o,
    output logic                 ext_pend_o,
    output logic                 irq_req_o,
    output logic [NUM_LINES-1:0] eoi_o
);

    localparam logic [NUM_LINES-1:0] OFF_EFF  = FEATURE_EN ? OFF_LINES[NUM_LINES-1:0] : '1;
    localparam logic [NUM_LINES-1:0] EDGE_EFF = EDGE_LINES[NUM_LINES-1:0];
    localparam logic [NUM_LINES-1:0] ALLOWED  = ~OFF_EFF;

    typedef struct packed {
        logic [NUM_LINES-1:0] mask;
        logic [NUM_LINES-1:0] pend;
        logic [NUM_LINES-1:0] eoi;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic                 mask_wr;
    logic                 pend_wr;
    logic [NUM_LINES-1:0] mask_nv;
    logic [NUM_LINES-1:0] pend_nv;
    logic [NUM_LINES-1:0] pend_next;
    logic [NUM_LINES-1:0] eoi_next;
    logic [NUM_LINES-1:0] pend_now;

    ext_irq_csr_port #(.NL(NUM_LINES)) u_port (
        .en_i      (csr_en_i),
        .addr_i    (csr_addr_i),
        .op_i      (csr_op_i),
        .wdata_i   (csr_wdata_i),
        .mask_q_i  (st_q.mask),
        .pend_q_i  (st_q.pend),
        .mask_wr_o (mask_wr),
        .pend_wr_o (pend_wr),
        .mask_nv_o (mask_nv),
        .pend_nv_o (pend_nv),
        .rdata_o   (csr_rdata_o)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        ext_irq_line #(
            .LATCHED (EDGE_EFF[i]),
            .OFF     (OFF_EFF[i])
        ) u_line (
            .irq_i    (irq_i[i]),
            .pend_q_i (st_q.pend[i]),
            .sw_wr_i  (pend_wr),
            .sw_val_i (pend_nv[i]),
            .pend_d_o (pend_next[i]),
            .eoi_d_o  (eoi_next[i])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.pend = pend_next;
        st_d.eoi  = eoi_next;
        if (mask_wr) begin
            st_d.mask = mask_nv & ALLOWED;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_now   = st_q.pend;
    assign ext_pend_o = |(st_q.pend & st_q.mask);
    assign irq_req_o  = ext_pend_o & glb_en_i;
    assign eoi_o      = st_q.eoi;

endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk #(
    parameter int unsigned   NL       = 32,
    parameter logic [NL-1:0] OFF_MSK  = '0,
    parameter logic [NL-1:0] EDGE_MSK = '1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NL-1:0] irq_i,
    input logic          glb_en_i,
    input logic          ext_pend_o,
    input logic          irq_req_o,
    input logic [NL-1:0] eoi_o,
    input logic [NL-1:0] pend_now,
    input logic          pend_wr
);

    localparam logic [NL-1:0] LEVEL_MSK = ~OFF_MSK & ~EDGE_MSK;
    localparam logic [NL-1:0] HOLD_MSK  = ~OFF_MSK & EDGE_MSK;

    logic warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm_q <= 1'b0;
        else        warm_q <= 1'b1;
    end

    AST_OFF_NEVER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_now & OFF_MSK) == '0); // R3

    AST_REQ_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (glb_en_i && ext_pend_o)); // R7

    AST_LEVEL_TRACKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n || !warm_q)
        (pend_now & LEVEL_MSK) == ($past(irq_i) & LEVEL_MSK)); // R5

    AST_LATCH_FALLS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n || !warm_q)
        ((($past(pend_now) & ~pend_now) & HOLD_MSK) != '0) |-> $past(pend_wr)); // R4

    AST_EOI_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n || !warm_q)
        (($past(pend_now) & ~pend_now & eoi_o) == eoi_o)); // R8

    AST_EOI_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n || !warm_q)
        ((eoi_o & $past(eoi_o)) == '0)); // R8

endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(
    .NL       (NUM_LINES),
    .OFF_MSK  (OFF_EFF),
    .EDGE_MSK (EDGE_EFF)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_i      (irq_i),
    .glb_en_i   (glb_en_i),
    .ext_pend_o (ext_pend_o),
    .irq_req_o  (irq_req_o),
    .eoi_o      (eoi_o),
    .pend_now   (pend_now),
    .pend_wr    (pend_wr)
);

// File: tb/ext_irq_ctrl_bench.sv
`timescale 1ns/1ps
module ext_irq_ctrl_bench;

    localparam logic [31:0] OFF  = 32'h0000_0F00;
    localparam logic [31:0] EDGE = 32'h0000_00FF;
    localparam logic [11:0] A_EN = 12'h7C0;
    localparam logic [11:0] A_PD = 12'h7C1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq = '0;
    logic        en = 1'b0;
    logic [11:0] addr = '0;
    logic [1:0]  op = '0;
    logic [31:0] wdata = '0;
    logic        gen = 1'b0;

    logic [31:0] rdata, rdata_off, eoi, eoi_off;
    logic        meip, meip_off, req, req_off;

    always #2.5 clk = ~clk;

    ext_irq_ctrl #(.OFF_LINES(OFF), .EDGE_LINES(EDGE)) u_ext_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .csr_en_i(en), .csr_addr_i(addr),
        .csr_op_i(op), .csr_wdata_i(wdata), .glb_en_i(gen),
        .csr_rdata_o(rdata), .ext_pend_o(meip), .irq_req_o(req), .eoi_o(eoi));

    ext_irq_ctrl #(.OFF_LINES(OFF), .EDGE_LINES(EDGE), .FEATURE_EN(1'b0)) u_off (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .csr_en_i(en), .csr_addr_i(addr),
        .csr_op_i(op), .csr_wdata_i(wdata), .glb_en_i(gen),
        .csr_rdata_o(rdata_off), .ext_pend_o(meip_off), .irq_req_o(req_off), .eoi_o(eoi_off));

    typedef struct {
        string       tag;
        int          sel;
        logic [31:0] exp;
    } item_t;

    item_t q[$];
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // reference state
    logic [31:0] m_mask = '0, m_pend = '0, m_eoi = '0;

    function automatic logic [31:0] sample(int sel);
        case (sel)
            0: return rdata;
            1: return {31'b0, meip};
            2: return {31'b0, req};
            3: return eoi;
            default: return {rdata_off | eoi_off, 30'b0, meip_off, req_off} == '0 ? 32'd0
                            : (rdata_off | eoi_off | {30'b0, meip_off, req_off});
        endcase
    endfunction

    // monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            act = sample(it.sel);
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s out%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
            end
        end
    end

    function automatic logic [31:0] apply(logic [1:0] o, logic [31:0] old, logic [31:0] a);
        case (o)
            2'b01:   return a;
            2'b10:   return old | a;
            2'b11:   return old & ~a;
            default: return old;
        endcase
    endfunction

    // driver: one cycle of stimulus, expectations pushed for that cycle
    task automatic step(input logic e, input logic [1:0] o, input logic [11:0] a,
                        input logic [31:0] d, input logic [31:0] ir, input logic g,
                        input string tag);
        logic [31:0] exp_rd, sw, nxt;
        logic        wr, mp;
        item_t it;
        @(posedge clk); #1;
        en = e; op = o; addr = a; wdata = d; irq = ir; gen = g;
        exp_rd = !e ? 32'd0 : (a == A_EN) ? m_mask : (a == A_PD) ? m_pend : 32'd0;
        mp = |(m_pend & m_mask);
        it.tag = tag; it.sel = 0; it.exp = exp_rd;              q.push_back(it);
        it.tag = tag; it.sel = 1; it.exp = {31'b0, mp};         q.push_back(it);
        it.tag = tag; it.sel = 2; it.exp = {31'b0, mp & g};     q.push_back(it);
        it.tag = tag; it.sel = 3; it.exp = m_eoi;               q.push_back(it);
        it.tag = "R10"; it.sel = 4; it.exp = 32'd0;             q.push_back(it);
        wr = e && (o != 2'b00);
        sw = (wr && a == A_PD) ? apply(o, m_pend, d) : m_pend;
        nxt = (((sw | ir) & EDGE) | (ir & ~EDGE)) & ~OFF;
        m_eoi = m_pend & ~nxt & EDGE & ~OFF;
        if (wr && a == A_EN) m_mask = apply(o, m_mask, d) & ~OFF;
        m_pend = nxt;
    endtask

    task automatic idle(input int n, input logic [31:0] ir, input logic g, input string tag);
        for (int k = 0; k < n; k++) step(1'b1, 2'b00, A_PD, 32'h0, ir, g, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        step(1'b1, 2'b00, A_EN, 32'h0, 32'h0, 1'b0, "R1");
        step(1'b1, 2'b00, A_PD, 32'h0, 32'h0, 1'b1, "R1");
        // R2 / R3: enable register operations and decode
        step(1'b1, 2'b01, A_EN, 32'hFFFF_FFFF, 32'h0, 1'b0, "R2");
        step(1'b1, 2'b00, A_EN, 32'h0, 32'h0, 1'b0, "R3");
        step(1'b1, 2'b11, A_EN, 32'hFFFF_0000, 32'h0, 1'b0, "R2");
        step(1'b1, 2'b10, A_EN, 32'h0001_0000, 32'h0, 1'b0, "R2");
        step(1'b1, 2'b00, A_EN, 32'hFFFF_FFFF, 32'h0, 1'b0, "R2");
        step(1'b1, 2'b01, 12'h7C5, 32'h0, 32'h0, 1'b0, "R2");
        step(1'b0, 2'b01, A_EN, 32'h0, 32'h0, 1'b0, "R2");
        step(1'b1, 2'b00, A_EN, 32'h0, 32'h0, 1'b0, "R2");
        // R4 / R6 / R7: latched pulse on line 3
        step(1'b1, 2'b00, A_PD, 32'h0, 32'h0000_0008, 1'b0, "R4");
        idle(3, 32'h0, 1'b0, "R6");
        idle(2, 32'h0, 1'b1, "R7");
        // R8: clear while masked and globally disabled
        step(1'b1, 2'b11, A_EN, 32'h0000_0008, 32'h0, 1'b0, "R6");
        step(1'b1, 2'b11, A_PD, 32'h0000_0008, 32'h0, 1'b0, "R8");
        idle(3, 32'h0, 1'b0, "R8");
        // R9: clear coinciding with a new pulse on line 5
        step(1'b1, 2'b00, A_PD, 32'h0, 32'h0000_0020, 1'b1, "R9");
        step(1'b1, 2'b11, A_PD, 32'h0000_0020, 32'h0000_0020, 1'b1, "R9");
        idle(2, 32'h0, 1'b1, "R9");
        step(1'b1, 2'b01, A_PD, 32'h0, 32'h0, 1'b1, "R8");
        idle(2, 32'h0, 1'b1, "R8");
        // R5: level line 20 follows input, writes ignored
        idle(2, 32'h0010_0000, 1'b1, "R5");
        step(1'b1, 2'b11, A_PD, 32'hFFFF_FFFF, 32'h0010_0000, 1'b1, "R5");
        idle(2, 32'h0010_0000, 1'b1, "R5");
        step(1'b1, 2'b10, A_PD, 32'h0020_0000, 32'h0, 1'b1, "R5");
        idle(2, 32'h0, 1'b1, "R5");
        // R3: activity on switched-off lines
        idle(3, 32'h0000_0F00, 1'b1, "R3");
        step(1'b1, 2'b10, A_PD, 32'h0000_0F00, 32'h0, 1'b1, "R3");
        idle(2, 32'h0, 1'b1, "R3");
        // R6: multiple enabled pending lines
        step(1'b1, 2'b01, A_EN, 32'h0000_0003, 32'h0000_00C3, 1'b1, "R6");
        idle(2, 32'h0, 1'b1, "R6");
        step(1'b1, 2'b11, A_PD, 32'h0000_0001, 32'h0, 1'b1, "R6");
        step(1'b1, 2'b11, A_PD, 32'h0000_0002, 32'h0, 1'b1, "R6");
        idle(3, 32'h0, 1'b1, "R6");
        @(posedge clk); #1;
        @(negedge clk); #0.5;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule